// File: doc/BRIEF.md
# Fractional-Rate Phase-Accumulator Counter

This block advances an 8-bit counter at an average rate of x/y increments per clock, where x is a programmable step and y is a programmable modulus. On every clock a phase accumulator adds the step. Whenever the running sum reaches or passes the modulus, the block subtracts the modulus, keeps the remainder, and advances the counter by one. The mean time spent on each count value is therefore y/x clocks, which need not be a whole number. For example, with y = 512 and x = 40 the counter holds each value for 12.8 clocks on average.

The modulus may be any value from 1 up to a build-time maximum, so it does not have to be a power of two. A parameter can instead fix the modulus at a power-of-two maximum. In that case the carry is taken from one bit of the sum and the modulus input is ignored. Alongside the count value, the block emits a one-clock strobe on each increment. Step and modulus are expected to stay constant between resets.

Top module: `fracRateCounter`

## Requirements
- R1: A clock edge with `rst` high leaves `countOut` at 0 and `incStrobe` low in the following cycle, and clears the accumulator to 0.
- R2: `countOut` rises by exactly one in each cycle in which `incStrobe` is high, holds its value in every other cycle, and wraps from 255 to 0.
- R3: With x and y held constant (1 <= y <= MOD_MAX, 0 <= x <= y), after n clock edges since reset was released `countOut` equals floor(n*x/y) mod 256.
- R4: After edge n, `incStrobe` is high exactly when floor(n*x/y) - floor((n-1)*x/y) is 1, so each carry gives a single-cycle pulse.
- R5: A step of x = 0 is legal and produces no strobe and no count change.
- R6: A step equal to the modulus (x = y) produces a strobe on every clock after reset.
- R7: Moduli that are not powers of two, such as 460, give the exact x/y strobe count of R3.
- R8: The largest modulus, y = MOD_MAX = 512, is accepted. With x = 1, exactly one strobe occurs every 512 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stepIn | input | 10 | Step x added to the accumulator each clock (STEP_W bits) |
| modIn | input | 10 | Modulus y; the accumulator wraps at this value (STEP_W bits) |
| countOut | output | 8 | Output count value (COUNT_W bits) |
| incStrobe | output | 1 | High for one cycle on each count increment |

## Verification
The accumulator, the counter and the strobe are all registers fed from the same edge. Both results of edge n are therefore visible in the cycle that follows it, with no further latency. The bench drives reset and configuration on the falling edge. It then waits one rising edge followed by a falling edge, so that the expected values floor(n*x/y) mod 256 and the strobe difference for exactly that n are compared against settled outputs. The reset state is sampled on the falling edge after the first reset edge, before reset is released.

// File: rtl/fracRatePkg.sv
package fracRatePkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;  // zero all state this edge
    logic carry;  // subtract modulus and advance the count this edge
  } accCtrl_t;

endpackage

// File: rtl/frcControl.sv
module frcControl
  import fracRatePkg::*;
#(
  parameter int STEP_W  = 10,
  parameter int SUM_W   = 11,
  parameter int MOD_MAX = 512,
  parameter bit FIXED_POW2_MOD = 1'b0
) (
  input  logic              rst,
  input  logic [SUM_W-1:0]  sumIn,
  input  logic [STEP_W-1:0] modIn,
  output logic [STEP_W-1:0] modEff,
  output accCtrl_t          ctrl
);

  logic carryRaw;

  generate
    if (FIXED_POW2_MOD) begin : g_fixedMod
      // Modulus is a power of two: the carry is the weight-MOD_MAX bit of the sum
      localparam int CARRY_BIT = $clog2(MOD_MAX);
      assign carryRaw = sumIn[CARRY_BIT];
      assign modEff   = STEP_W'(MOD_MAX);
    end else begin : g_compareMod
      // Arbitrary modulus: magnitude compare of the sum against y
      assign carryRaw = (sumIn >= {{(SUM_W-STEP_W){1'b0}}, modIn});
      assign modEff   = modIn;
    end
  endgenerate

  always_comb begin
    ctrl.clear = rst;
    ctrl.carry = carryRaw && !rst;
  end

endmodule

// File: rtl/frcDatapath.sv
module frcDatapath
  import fracRatePkg::*;
#(
  parameter int COUNT_W = 8,
  parameter int STEP_W  = 10,
  parameter int SUM_W   = 11
) (
  input  logic               clk,
  input  accCtrl_t           ctrl,
  input  logic [STEP_W-1:0]  stepIn,
  input  logic [STEP_W-1:0]  modEff,
  output logic [SUM_W-1:0]   sumOut,
  output logic [COUNT_W-1:0] countOut,
  output logic               incStrobe
);

  logic [STEP_W-1:0] phaseAcc;
  logic [SUM_W-1:0]  wrapped;

  always_comb begin
    sumOut  = {1'b0, phaseAcc} + {1'b0, stepIn};
    wrapped = sumOut - {1'b0, modEff};
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      phaseAcc  <= '0;
      countOut  <= '0;
      incStrobe <= 1'b0;
    end else begin
      incStrobe <= ctrl.carry;
      if (ctrl.carry) begin
        phaseAcc <= wrapped[STEP_W-1:0];
        countOut <= countOut + 1'b1;
      end else begin
        phaseAcc <= sumOut[STEP_W-1:0];
      end
    end
  end

endmodule

// File: rtl/fracRateCounter.sv
module fracRateCounter
  import fracRatePkg::*;
#(
  parameter int COUNT_W = 8,
  parameter int MOD_MAX = 512,
  parameter bit FIXED_POW2_MOD = 1'b0,
  localparam int STEP_W = $clog2(MOD_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STEP_W-1:0]  stepIn,
  input  logic [STEP_W-1:0]  modIn,
  output logic [COUNT_W-1:0] countOut,
  output logic               incStrobe
);

  localparam int SUM_W = STEP_W + 1;

  accCtrl_t          ctrl;
  logic [SUM_W-1:0]  sumVal;
  logic [STEP_W-1:0] modEff;

  frcControl #(
    .STEP_W(STEP_W), .SUM_W(SUM_W), .MOD_MAX(MOD_MAX), .FIXED_POW2_MOD(FIXED_POW2_MOD)
  ) i_control (
    .rst(rst), .sumIn(sumVal), .modIn(modIn), .modEff(modEff), .ctrl(ctrl)
  );

  frcDatapath #(
    .COUNT_W(COUNT_W), .STEP_W(STEP_W), .SUM_W(SUM_W)
  ) i_datapath (
    .clk(clk), .ctrl(ctrl), .stepIn(stepIn), .modEff(modEff),
    .sumOut(sumVal), .countOut(countOut), .incStrobe(incStrobe)
  );

endmodule

// File: rtl/fracRateCounterChk.sv
module fracRateCounterChk #(
  parameter int COUNT_W = 8,
  parameter int MOD_MAX = 512,
  localparam int STEP_W = $clog2(MOD_MAX + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic [STEP_W-1:0]  stepIn,
  input logic [STEP_W-1:0]  modIn,
  input logic [COUNT_W-1:0] countOut,
  input logic               incStrobe
);

  logic seenRst = 1'b0;
  always_ff @(posedge clk) if (rst) seenRst <= 1'b1;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (countOut == '0 && !incStrobe));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst || !seenRst)
    (!$past(rst) && incStrobe) |-> countOut == $past(countOut) + 1'b1);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst || !seenRst)
    (!$past(rst) && !incStrobe) |-> $stable(countOut));

  // R5
  zero_step_chk: assert property (@(posedge clk) disable iff (rst || !seenRst)
    (!$past(rst) && $past(stepIn) == '0 && $past(modIn) != '0) |-> !incStrobe);

  // R6
  full_step_chk: assert property (@(posedge clk) disable iff (rst || !seenRst)
    (!$past(rst) && $past(modIn) != '0 && $past(stepIn) == $past(modIn)) |-> incStrobe);

endmodule

bind fracRateCounter fracRateCounterChk #(.COUNT_W(COUNT_W), .MOD_MAX(MOD_MAX)) i_chk (.*);

// File: tb/test_fracRateCounter.sv
`timescale 1ns/1ps
module test_fracRateCounter;

  localparam int COUNT_W = 8;
  localparam int MOD_MAX = 512;
  localparam int STEP_W  = $clog2(MOD_MAX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [STEP_W-1:0]  stepIn = '0;
  logic [STEP_W-1:0]  modIn  = 10'd1;
  logic [COUNT_W-1:0] countOut;
  logic               incStrobe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fracRateCounter #(.COUNT_W(COUNT_W), .MOD_MAX(MOD_MAX)) i_fracRateCounter (
    .clk(clk), .rst(rst), .stepIn(stepIn), .modIn(modIn),
    .countOut(countOut), .incStrobe(incStrobe)
  );

  always @(posedge clk) cycles <= cycles + 1;

  initial begin : watchdog
    wait (cycles > 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer than 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic string countTag(int x, int y, longint total);
    if (total >= 256) return "R2";
    if (y == 460)     return "R7";
    if (x == 0)       return "R5";
    if (x == y)       return "R6";
    if (y == 512)     return "R8";
    return "R3";
  endfunction

  task automatic runCase(int x, int y, int nCycles);
    @(negedge clk);
    rst = 1'b1; stepIn = STEP_W'(x); modIn = STEP_W'(y);
    @(posedge clk); @(negedge clk);
    checks++;
    if (countOut !== '0 || incStrobe !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset x=%0d y=%0d: actual count=%0d strobe=%b, expected count=0 strobe=0",
               x, y, countOut, incStrobe);
    end
    rst = 1'b0;
    for (int n = 1; n <= nCycles; n++) begin
      longint tot, prevTot, expCount, expStb;
      @(posedge clk); @(negedge clk);
      tot      = (longint'(n) * x) / y;
      prevTot  = (longint'(n - 1) * x) / y;
      expCount = tot % 256;
      expStb   = tot - prevTot;
      checks++;
      if (countOut !== COUNT_W'(expCount)) begin
        fails++;
        $display("FAIL %s count x=%0d y=%0d n=%0d: actual %0d, expected %0d",
                 countTag(x, y, tot), x, y, n, countOut, expCount);
      end
      checks++;
      if (incStrobe !== expStb[0]) begin
        fails++;
        $display("FAIL R4 strobe x=%0d y=%0d n=%0d: actual %b, expected %0d",
                 x, y, n, incStrobe, expStb);
      end
    end
  endtask

  initial begin
    // Near-exhaustive sweep over small moduli: R3, R4, R5, R6
    for (int y = 1; y <= 12; y++)
      for (int x = 0; x <= y; x++)
        runCase(x, y, 3 * y + 7);
    // Large moduli and boundary steps
    runCase(1, 512, 1100);    // R8
    runCase(40, 512, 2000);   // R8: 12.8 clocks mean hold
    runCase(40, 460, 2000);   // R7
    runCase(459, 460, 1000);  // R7
    runCase(7, 460, 1500);    // R7
    runCase(0, 460, 600);     // R5 / R7
    runCase(512, 512, 600);   // R2 wrap, R6
    runCase(300, 301, 1200);  // R2 wrap
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule